// File: doc/BRIEF.md
# Stacked-DRAM Region Activity Budget Gate

This block sits in the command path of a memory controller for an eight-die DRAM stack. Each cycle the scheduler presents one candidate command: a read, write, activate or precharge, aimed at a stack region. The block answers at once whether that command may issue without exceeding the supply-drop budgets set for the stack. One region maps to one die level, with region 0 at the bottom, next to the supply entry. Region 7 is at the top.

Every command is weighted by its load relative to a read. Weights are kept in sixths of a read so that all of them are whole numbers. An accepted command charges its weight to its region for a programmable number of cycles. A pool of tracking slots then removes the charge. A candidate is allowed only if four checks still hold once its weight is added: its own region, each adjacent pair that contains the region, its half of the stack, and the whole stack. The whole-stack budget shrinks whenever a read is active in the upper half. The per-region, per-pair and per-half budgets are static inputs. They are set by a supply-network analysis outside this block.

Top module: `ir_budget_gate`

## Requirements
- R1: An accepted command adds its weight to the occupancy of its region on `occ_o`, visible in the cycle after acceptance. The command code on `cand_cmd_i` selects the weight: 0 is a read (6), 1 is a write (6), 2 is an activate (3) and 3 is a precharge (1). Region r occupies `occ_o[8r+7:8r]`.
- R2: The charge stays in place for exactly `win_i` cycles and is then removed. A `win_i` of 0 behaves like 1.
- R3: `allow_o` is low when the region's occupancy plus the candidate's weight would exceed that region's limit. The limit for region r is `reg_lim_i[8r+7:8r]`. Reaching the limit exactly is allowed.
- R4: `allow_o` is low when an adjacent pair that contains the candidate's region would exceed its limit. Pair p covers regions p and p+1, and its limit is `pair_lim_i[8p+7:8p]`.
- R5: `allow_o` is low when the candidate's half of the stack would exceed its limit. Regions 0 to 3 form the lower half, with its limit in `half_lim_i[7:0]`. Regions 4 to 7 form the upper half, with its limit in `half_lim_i[15:8]`.
- R6: The total across all regions, after adding the candidate, may not exceed 96 units (16 reads). It may not exceed 48 units (8 reads) while a read is active in an upper region, or when the candidate is itself an upper-region read.
- R7: `allow_o` is low while all 24 tracking slots hold active charges.
- R8: A command is charged only when `cand_vld_i` and `allow_o` are both high. A cycle with `cand_vld_i` low leaves the occupancy unchanged, apart from expiries.
- R9: When a charge and an expiry hit the same region in the same cycle, both take effect.
- R10: After reset, every region's occupancy is 0 and `allow_o` is high for any candidate that fits the limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cand_vld_i | input | 1 | Candidate command present; it is issued when allow_o is also high |
| cand_cmd_i | input | 2 | Command code (0 read, 1 write, 2 activate, 3 precharge) |
| cand_reg_i | input | 3 | Target region, 0 at the bottom |
| win_i | input | 8 | Charge duration in cycles |
| reg_lim_i | input | 64 | Per-region limits, 8 bits each, in sixths of a read |
| pair_lim_i | input | 56 | Adjacent-pair limits, 8 bits each |
| half_lim_i | input | 16 | Lower-half and upper-half limits |
| allow_o | output | 1 | The candidate fits every budget |
| occ_o | output | 64 | Per-region occupancy, 8 bits each |

## Verification
`allow_o` is combinational: it answers for the candidate in the same cycle. The bench drives each candidate on the falling edge and reads `allow_o` 1 ns later. Occupancy changes on the rising edge that accepts a command or retires a slot, so `occ_o` is sampled 1 ns after that edge and compared with a reference model that has just been stepped by one cycle. The expiry and same-cycle tests count edges from the accepting edge, with `win_i` set so that the retiring edge lands on a known step.

// File: rtl/ir_budget_pkg.sv
package ir_budget_pkg;

  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_WR  = 2'd1,
    CMD_ACT = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  localparam int unsigned COST_W = 3;

  // weight in sixths of a read
  function automatic logic [COST_W-1:0] cmd_cost(cmd_e c);
    case (c)
      CMD_RD:  return 3'd6;
      CMD_WR:  return 3'd6;
      CMD_ACT: return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/ir_slot_pool.sv
module ir_slot_pool
  import ir_budget_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = 24,
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned WIN_W       = 8,
  parameter int unsigned OCC_W       = 8,
  parameter int unsigned REG_W       = 3,
  parameter int unsigned CNT_W       = 5
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                load_i,
  input  logic [REG_W-1:0]                    load_reg_i,
  input  logic [COST_W-1:0]                   load_cost_i,
  input  logic                                load_toprd_i,
  input  logic [WIN_W-1:0]                    win_i,
  output logic                                slot_free_o,
  output logic [NUM_REGIONS-1:0][OCC_W-1:0]   exp_cost_o,
  output logic [CNT_W-1:0]                    exp_toprd_o
);

  logic [NUM_SLOTS-1:0]             act_q;
  logic [NUM_SLOTS-1:0][WIN_W-1:0]  cnt_q;
  logic [NUM_SLOTS-1:0][REG_W-1:0]  reg_q;
  logic [NUM_SLOTS-1:0][COST_W-1:0] cost_q;
  logic [NUM_SLOTS-1:0]             trd_q;
  logic [NUM_SLOTS-1:0]             grant;
  logic [NUM_SLOTS-1:0]             expire;
  logic [WIN_W-1:0]                 win_eff;
  logic                             found;

  assign win_eff = (win_i == '0) ? WIN_W'(1) : win_i;

  // lowest free slot
  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!act_q[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
  assign slot_free_o = found;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign expire[g] = act_q[g] && (cnt_q[g] == WIN_W'(1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q[g]  <= 1'b0;
        cnt_q[g]  <= '0;
        reg_q[g]  <= '0;
        cost_q[g] <= '0;
        trd_q[g]  <= 1'b0;
      end else if (load_i && grant[g]) begin
        act_q[g]  <= 1'b1;
        cnt_q[g]  <= win_eff;
        reg_q[g]  <= load_reg_i;
        cost_q[g] <= load_cost_i;
        trd_q[g]  <= load_toprd_i;
      end else if (expire[g]) begin
        act_q[g]  <= 1'b0;
        cnt_q[g]  <= '0;
      end else if (act_q[g]) begin
        cnt_q[g]  <= cnt_q[g] - WIN_W'(1);
      end
    end
  end

  always_comb begin
    exp_cost_o  = '0;
    exp_toprd_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (expire[i]) begin
        exp_cost_o[reg_q[i]] = exp_cost_o[reg_q[i]] + OCC_W'(cost_q[i]);
        if (trd_q[i]) exp_toprd_o = exp_toprd_o + CNT_W'(1);
      end
    end
  end

  // R7
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  // R2
  load_fills_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && slot_free_o) |=> ($countones(act_q) >= 1));

endmodule

// File: rtl/ir_occupancy.sv
module ir_occupancy
  import ir_budget_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned OCC_W       = 8,
  parameter int unsigned REG_W       = 3,
  parameter int unsigned CNT_W       = 5
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              chg_i,
  input  logic [REG_W-1:0]                  chg_reg_i,
  input  logic [COST_W-1:0]                 chg_cost_i,
  input  logic                              chg_toprd_i,
  input  logic [NUM_REGIONS-1:0][OCC_W-1:0] exp_cost_i,
  input  logic [CNT_W-1:0]                  exp_toprd_i,
  output logic [NUM_REGIONS-1:0][OCC_W-1:0] occ_o,
  output logic                              top_busy_o
);

  logic [NUM_REGIONS-1:0][OCC_W-1:0] occ_q, occ_d;
  logic [CNT_W-1:0]                  toprd_q, toprd_d;

  always_comb begin
    for (int r = 0; r < NUM_REGIONS; r++) begin
      occ_d[r] = occ_q[r] - exp_cost_i[r];
      if (chg_i && (chg_reg_i == REG_W'(r)))
        occ_d[r] = occ_d[r] + OCC_W'(chg_cost_i);
    end
    toprd_d = toprd_q - exp_toprd_i + ((chg_i && chg_toprd_i) ? CNT_W'(1) : CNT_W'(0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q   <= '0;
      toprd_q <= '0;
    end else begin
      occ_q   <= occ_d;
      toprd_q <= toprd_d;
    end
  end

  assign occ_o      = occ_q;
  assign top_busy_o = (toprd_q != '0);

  // R8
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chg_i && (exp_cost_i == '0)) |=> $stable(occ_q));

endmodule

// File: rtl/ir_limit_check.sv
module ir_limit_check
  import ir_budget_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned OCC_W       = 8,
  parameter int unsigned LIM_W       = 8,
  parameter int unsigned REG_W       = 3,
  parameter int unsigned SUM_W       = 12,
  parameter int unsigned STACK_RD_HI = 16,
  parameter int unsigned STACK_RD_LO = 8
) (
  input  logic [NUM_REGIONS-1:0][OCC_W-1:0]   occ_i,
  input  logic [REG_W-1:0]                    reg_i,
  input  logic [COST_W-1:0]                   cost_i,
  input  logic                                toprd_i,
  input  logic                                top_busy_i,
  input  logic                                slot_free_i,
  input  logic [NUM_REGIONS*LIM_W-1:0]        reg_lim_i,
  input  logic [(NUM_REGIONS-1)*LIM_W-1:0]    pair_lim_i,
  input  logic [2*LIM_W-1:0]                  half_lim_i,
  output logic                                allow_o
);

  localparam int unsigned HALF = NUM_REGIONS / 2;
  localparam logic [SUM_W-1:0] STK_HI_U = SUM_W'(STACK_RD_HI * 6);
  localparam logic [SUM_W-1:0] STK_LO_U = SUM_W'(STACK_RD_LO * 6);

  logic [SUM_W-1:0] cst, own, lo_nb, hi_nb, half_sum [2], total;
  logic [REG_W-1:0] idx_lo, idx_hi;
  logic             in_top, first, last;
  logic             reg_ok, pair_lo_ok, pair_hi_ok, half_ok, stack_ok;

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_comb begin
      half_sum[h] = '0;
      for (int r = h * HALF; r < (h + 1) * HALF; r++)
        half_sum[h] = half_sum[h] + SUM_W'(occ_i[r]);
    end
  end

  always_comb begin
    cst    = SUM_W'(cost_i);
    own    = SUM_W'(occ_i[reg_i]);
    first  = (reg_i == '0);
    last   = (reg_i == REG_W'(NUM_REGIONS - 1));
    idx_lo = first ? reg_i : reg_i - REG_W'(1);
    idx_hi = last  ? reg_i - REG_W'(1) : reg_i;
    lo_nb  = SUM_W'(occ_i[idx_lo]);
    hi_nb  = SUM_W'(occ_i[last ? reg_i : reg_i + REG_W'(1)]);
    in_top = (reg_i >= REG_W'(HALF));
    total  = half_sum[0] + half_sum[1];

    reg_ok     = (own + cst) <= SUM_W'(reg_lim_i[reg_i*LIM_W +: LIM_W]);
    pair_lo_ok = first || ((lo_nb + own + cst) <= SUM_W'(pair_lim_i[idx_lo*LIM_W +: LIM_W]));
    pair_hi_ok = last  || ((own + hi_nb + cst) <= SUM_W'(pair_lim_i[idx_hi*LIM_W +: LIM_W]));
    half_ok    = (half_sum[in_top] + cst) <= SUM_W'(half_lim_i[in_top*LIM_W +: LIM_W]);
    stack_ok   = (total + cst) <= ((top_busy_i || toprd_i) ? STK_LO_U : STK_HI_U);

    allow_o = slot_free_i && reg_ok && pair_lo_ok && pair_hi_ok && half_ok && stack_ok;
  end

endmodule

// File: rtl/ir_budget_gate.sv
module ir_budget_gate
  import ir_budget_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned NUM_SLOTS   = 24,
  parameter int unsigned WIN_W       = 8,
  parameter int unsigned STACK_RD_HI = 16,
  parameter int unsigned STACK_RD_LO = 8,
  localparam int unsigned OCC_W = $clog2(NUM_SLOTS * 6 + 1),
  localparam int unsigned LIM_W = OCC_W,
  localparam int unsigned REG_W = $clog2(NUM_REGIONS),
  localparam int unsigned CNT_W = $clog2(NUM_SLOTS + 1),
  localparam int unsigned SUM_W = OCC_W + REG_W + 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cand_vld_i,
  input  logic [1:0]                       cand_cmd_i,
  input  logic [REG_W-1:0]                 cand_reg_i,
  input  logic [WIN_W-1:0]                 win_i,
  input  logic [NUM_REGIONS*LIM_W-1:0]     reg_lim_i,
  input  logic [(NUM_REGIONS-1)*LIM_W-1:0] pair_lim_i,
  input  logic [2*LIM_W-1:0]               half_lim_i,
  output logic                             allow_o,
  output logic [NUM_REGIONS*OCC_W-1:0]     occ_o
);

  localparam int unsigned HALF = NUM_REGIONS / 2;

  cmd_e                              cmd;
  logic [COST_W-1:0]                 cost;
  logic                              toprd, issue, slot_free, top_busy;
  logic [NUM_REGIONS-1:0][OCC_W-1:0] occ, exp_cost;
  logic [CNT_W-1:0]                  exp_toprd;
  logic [SUM_W-1:0]                  total;

  assign cmd   = cmd_e'(cand_cmd_i);
  assign cost  = cmd_cost(cmd);
  assign toprd = (cmd == CMD_RD) && (cand_reg_i >= REG_W'(HALF));
  assign issue = cand_vld_i && allow_o;

  ir_slot_pool #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_REGIONS(NUM_REGIONS), .WIN_W(WIN_W),
    .OCC_W(OCC_W), .REG_W(REG_W), .CNT_W(CNT_W)
  ) i_pool (
    .clk_i, .rst_ni,
    .load_i(issue), .load_reg_i(cand_reg_i), .load_cost_i(cost),
    .load_toprd_i(toprd), .win_i,
    .slot_free_o(slot_free), .exp_cost_o(exp_cost), .exp_toprd_o(exp_toprd)
  );

  ir_occupancy #(
    .NUM_REGIONS(NUM_REGIONS), .OCC_W(OCC_W), .REG_W(REG_W), .CNT_W(CNT_W)
  ) i_occ (
    .clk_i, .rst_ni,
    .chg_i(issue), .chg_reg_i(cand_reg_i), .chg_cost_i(cost), .chg_toprd_i(toprd),
    .exp_cost_i(exp_cost), .exp_toprd_i(exp_toprd),
    .occ_o(occ), .top_busy_o(top_busy)
  );

  ir_limit_check #(
    .NUM_REGIONS(NUM_REGIONS), .OCC_W(OCC_W), .LIM_W(LIM_W), .REG_W(REG_W),
    .SUM_W(SUM_W), .STACK_RD_HI(STACK_RD_HI), .STACK_RD_LO(STACK_RD_LO)
  ) i_lim (
    .occ_i(occ), .reg_i(cand_reg_i), .cost_i(cost), .toprd_i(toprd),
    .top_busy_i(top_busy), .slot_free_i(slot_free),
    .reg_lim_i, .pair_lim_i, .half_lim_i,
    .allow_o
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_out
    assign occ_o[r*OCC_W +: OCC_W] = occ[r];
  end

  always_comb begin
    total = '0;
    for (int r = 0; r < NUM_REGIONS; r++) total = total + SUM_W'(occ[r]);
  end

  // R7
  issue_needs_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |-> slot_free);

  // R6
  stack_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    total <= SUM_W'(STACK_RD_HI * 6));

  // R6
  top_read_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_busy |-> (total <= SUM_W'(STACK_RD_LO * 6)));

  // R3
  region_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |=> (occ[$past(cand_reg_i)] <= $past(reg_lim_i[cand_reg_i*LIM_W +: LIM_W])));

endmodule

// File: tb/test_ir_budget_gate.sv
`timescale 1ns/1ps
module test_ir_budget_gate;

  localparam int NR = 8;
  localparam int NS = 24;
  localparam int W  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            vld = 1'b0;
  logic [1:0]      cmd = 2'd0;
  logic [2:0]      rgn = 3'd0;
  logic [7:0]      win = 8'd4;
  logic [NR*W-1:0] reg_lim;
  logic [(NR-1)*W-1:0] pair_lim;
  logic [2*W-1:0]  half_lim;
  logic            allow;
  logic [NR*W-1:0] occ;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ir_budget_gate i_ir_budget_gate (
    .clk_i(clk), .rst_ni(rst_n), .cand_vld_i(vld), .cand_cmd_i(cmd),
    .cand_reg_i(rgn), .win_i(win), .reg_lim_i(reg_lim), .pair_lim_i(pair_lim),
    .half_lim_i(half_lim), .allow_o(allow), .occ_o(occ)
  );

  // reference model
  int m_occ [NR];
  bit m_act [NS];
  int m_cnt [NS];
  int m_reg [NS];
  int m_cost[NS];
  bit m_trd [NS];

  function automatic int cost_of(int c);
    return (c == 0 || c == 1) ? 6 : (c == 2) ? 3 : 1;
  endfunction

  function automatic int occ_of(int r);
    return int'(occ[r*W +: W]);
  endfunction

  function automatic bit model_allow(int c, int r);
    int cst = cost_of(c);
    int tot = 0, hs = 0;
    bit trd = 0, free = 0, ok;
    for (int i = 0; i < NS; i++) begin
      if (m_act[i] && m_trd[i]) trd = 1;
      if (!m_act[i]) free = 1;
    end
    for (int k = 0; k < NR; k++) begin
      tot += m_occ[k];
      if ((k >= NR/2) == (r >= NR/2)) hs += m_occ[k];
    end
    ok = free && (m_occ[r] + cst <= int'(reg_lim[r*W +: W]));
    if (r > 0)    ok = ok && (m_occ[r-1] + m_occ[r] + cst <= int'(pair_lim[(r-1)*W +: W]));
    if (r < NR-1) ok = ok && (m_occ[r] + m_occ[r+1] + cst <= int'(pair_lim[r*W +: W]));
    ok = ok && (hs + cst <= int'(half_lim[(r >= NR/2)*W +: W]));
    ok = ok && (tot + cst <= ((trd || (c == 0 && r >= NR/2)) ? 48 : 96));
    return ok;
  endfunction

  task automatic model_update(bit acc, int c, int r);
    int ni = -1;
    if (acc) begin
      for (int i = 0; i < NS; i++) if (!m_act[i] && ni < 0) ni = i;
      m_act[ni] = 1; m_cnt[ni] = (win == 0) ? 1 : int'(win);
      m_reg[ni] = r; m_cost[ni] = cost_of(c); m_trd[ni] = (c == 0 && r >= NR/2);
      m_occ[r] += cost_of(c);
    end
    for (int i = 0; i < NS; i++) begin
      if (m_act[i] && i != ni) begin
        if (m_cnt[i] == 1) begin
          m_act[i] = 0;
          m_occ[m_reg[i]] -= m_cost[i];
        end else m_cnt[i]--;
      end
    end
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ex: 0/1 explicit expected allow, 2 = from model
  task automatic step(bit v, int c, int r, int ex, string tag);
    bit ea;
    bit occ_ok = 1;
    int bad_r = 0;
    @(negedge clk);
    vld = v; cmd = 2'(c); rgn = 3'(r);
    #1;
    ea = (ex == 2) ? model_allow(c, r) : bit'(ex);
    chk(allow == ea, tag, int'(allow), int'(ea));
    @(posedge clk);
    #1;
    model_update(v && ea, c, r);
    for (int k = 0; k < NR; k++)
      if (occ_of(k) != m_occ[k]) begin occ_ok = 0; bad_r = k; end
    chk(occ_ok, tag, occ_of(bad_r), m_occ[bad_r]);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 2, tag);
  endtask

  task automatic open_limits();
    reg_lim = '1; pair_lim = '1; half_lim = '1;
  endtask

  // {vld, cmd[1:0], region[2:0]}
  localparam logic [5:0] VEC [12] = '{
    {1'b1, 2'd0, 3'd0}, {1'b1, 2'd1, 3'd1}, {1'b1, 2'd2, 3'd2}, {1'b1, 2'd3, 3'd3},
    {1'b1, 2'd0, 3'd0}, {1'b0, 2'd0, 3'd5}, {1'b1, 2'd2, 3'd4}, {1'b0, 2'd3, 3'd6},
    {1'b1, 2'd0, 3'd7}, {1'b1, 2'd3, 3'd7}, {1'b0, 2'd0, 3'd0}, {1'b0, 2'd0, 3'd0}
  };

  initial begin
    for (int k = 0; k < NR; k++) m_occ[k] = 0;
    for (int i = 0; i < NS; i++) begin
      m_act[i] = 0; m_cnt[i] = 0; m_reg[i] = 0; m_cost[i] = 0; m_trd[i] = 0;
    end
    open_limits();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10
    chk(occ == '0, "R10 occupancy", int'(occ[7:0]), 0);
    chk(allow == 1'b1, "R10 allow", int'(allow), 1);

    // R1 weight table walk, with R9 overlap at entry 4 (window 4)
    win = 8'd4;
    for (int i = 0; i < 12; i++)
      step(VEC[i][5], int'(VEC[i][4:3]), int'(VEC[i][2:0]), 2, "R1");
    idle(6, "R2");

    // R1 explicit weights
    win = 8'd30;
    step(1, 2, 1, 1, "R1"); chk(occ_of(1) == 3, "R1 activate", occ_of(1), 3);
    step(1, 3, 1, 1, "R1"); chk(occ_of(1) == 4, "R1 precharge", occ_of(1), 4);
    step(1, 1, 1, 1, "R1"); chk(occ_of(1) == 10, "R1 write", occ_of(1), 10);
    // R8 invalid candidate is not charged
    step(0, 0, 1, 1, "R8"); chk(occ_of(1) == 10, "R8 no charge", occ_of(1), 10);
    idle(32, "R2");

    // R2 window length 1, and 0 treated as 1
    win = 8'd1;
    step(1, 0, 5, 1, "R2"); chk(occ_of(5) == 6, "R2 charged", occ_of(5), 6);
    step(0, 0, 0, 2, "R2"); chk(occ_of(5) == 0, "R2 released", occ_of(5), 0);
    win = 8'd0;
    step(1, 0, 5, 1, "R2"); chk(occ_of(5) == 6, "R2 zero window", occ_of(5), 6);
    step(0, 0, 0, 2, "R2"); chk(occ_of(5) == 0, "R2 zero released", occ_of(5), 0);

    // R9 charge and expiry in the same region and cycle
    win = 8'd2;
    step(1, 0, 6, 1, "R9");
    step(0, 0, 0, 2, "R9");
    step(1, 3, 6, 1, "R9"); chk(occ_of(6) == 1, "R9 both applied", occ_of(6), 1);
    idle(3, "R9");

    // R3 region limit, exact and one over
    win = 8'd50;
    reg_lim[0*W +: W] = 8'd13;
    step(1, 0, 0, 1, "R3");
    step(1, 0, 0, 1, "R3");
    step(1, 0, 0, 0, "R3");
    step(1, 2, 0, 0, "R3");
    step(1, 3, 0, 1, "R3"); chk(occ_of(0) == 13, "R3 exact", occ_of(0), 13);
    step(1, 3, 0, 0, "R3");
    step(1, 3, 1, 1, "R3");
    idle(52, "R3");
    open_limits();

    // R4 pair limit on regions 2 and 3
    pair_lim[2*W +: W] = 8'd9;
    step(1, 0, 2, 1, "R4");
    step(1, 2, 3, 1, "R4");
    step(1, 3, 3, 0, "R4");
    step(1, 3, 2, 0, "R4");
    step(1, 3, 4, 1, "R4");
    step(1, 3, 1, 1, "R4");
    idle(52, "R4");
    open_limits();

    // R5 upper half limit
    half_lim[1*W +: W] = 8'd12;
    step(1, 1, 4, 1, "R5");
    step(1, 1, 7, 1, "R5");
    step(1, 3, 5, 0, "R5");
    step(1, 3, 0, 1, "R5");
    idle(52, "R5");
    open_limits();

    // R6 full stack without upper reads
    win = 8'd60;
    for (int i = 0; i < 16; i++) step(1, 0, i % 4, 1, "R6");
    step(1, 3, 0, 0, "R6");
    step(1, 0, 4, 0, "R6");
    idle(62, "R6");

    // R6 upper read tightens the stack limit
    step(1, 0, 4, 1, "R6");
    for (int i = 0; i < 7; i++) step(1, 0, i % 4, 1, "R6");
    step(1, 3, 1, 0, "R6");
    step(1, 3, 5, 0, "R6");
    idle(62, "R6");

    // R7 all slots busy
    for (int i = 0; i < NS; i++) step(1, 3, i % NR, 1, "R7");
    step(1, 3, 0, 0, "R7");
    step(1, 3, 6, 0, "R7");
    idle(62, "R7");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule